// File: doc/BRIEF.md
# PCI Single-Transfer Master Sequencer

This block turns one request from the host-bus side into exactly one PCI transaction with a single data phase. The host side presents a command, an address, write data and byte enables, and pulses a request. The sequencer then owns the PCI control lines. It drives the address phase and the data phase, waits through target wait states, and releases the bus through one turnaround clock. It reports one of four outcomes: normal completion with captured read data, master abort, target abort, or retry.

The PCI lines are split into separate drive values, input values and output enables, so that pads or a tri-state wrapper can sit outside the block. Internally a control state machine sends load, multiplexer-select and enable strobes to a small address/data path. A parity stage drives even parity over AD and C/BE one clock after every clock in which AD is driven. Received parity is never checked.

Top module: `pci_mseq`

## Requirements
- R1: While reset is high, and in the clock after it, no PCI output enable is high and `done` is low.
- R2: In the clock after a request is sampled in idle, the address phase is driven. FRAME# is low, AD holds the request address, C/BE holds the command, IRDY# is driven high, and every enable is high.
- R3: The clock after the address phase is the only data phase. FRAME# is driven high and IRDY# is driven low in that same clock. On a write, AD carries the write data and C/BE carries the byte enables.
- R4: Command bit 0 selects the direction: 1 means write and 0 means read. On a read, AD is released in the first data clock, and TRDY#, STOP# and DEVSEL# are not used to end the transfer until the second data clock.
- R5: A data clock in which TRDY# and DEVSEL# are both low ends the transfer with status 0, even if STOP# is also low. On a read, the AD input of that clock is presented on `rdata`.
- R6: If DEVSEL# has been sampled high at every edge up to and including the end of the fifth clock counted from the address phase, the transfer ends with status 1 (master abort).
- R7: STOP# low while DEVSEL# is high ends the transfer with status 2 (target abort).
- R8: STOP# low with DEVSEL# low and TRDY# high ends the transfer with status 3 (retry), so that the host can reissue the request.
- R9: In the clock after the ending edge, `done` is high for one clock. IRDY# is driven high, and FRAME#, AD and C/BE are released. In the clock after that, IRDY# is released too.
- R10: In each clock that follows a clock in which AD was driven, PAR is driven and equals the XOR of that clock's AD and C/BE. After a clock with AD released, PAR is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request, sampled while idle |
| req_cmd | input | 4 | PCI command for the address phase |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Active-low byte enables for the data phase |
| frame_n_o | output | 1 | FRAME# drive value |
| frame_oe | output | 1 | FRAME# enable |
| irdy_n_o | output | 1 | IRDY# drive value |
| irdy_oe | output | 1 | IRDY# enable |
| devsel_n_i | input | 1 | DEVSEL# from the bus |
| trdy_n_i | input | 1 | TRDY# from the bus |
| stop_n_i | input | 1 | STOP# from the bus |
| ad_o | output | 32 | AD drive value |
| ad_oe | output | 1 | AD enable |
| ad_i | input | 32 | AD from the bus |
| cbe_o | output | 4 | C/BE drive value |
| cbe_oe | output | 1 | C/BE enable |
| par_o | output | 1 | PAR drive value |
| par_oe | output | 1 | PAR enable |
| done | output | 1 | One-clock end-of-transfer flag |
| status | output | 2 | 0 ok, 1 master abort, 2 target abort, 3 retry |
| rdata | output | 32 | Data captured on a completed read |

## Verification
Two pairs of events can fall in the same data clock. First, TRDY# and STOP# can both be low, which is a disconnect that still carries data. Second, DEVSEL# can arrive at the very clock in which the master-abort limit expires. The stimulus table includes a read whose target lowers TRDY# and STOP# together, and a write whose DEVSEL# and TRDY# first go low in the fourth data clock. The bench judges both cases against an independent model of the outcome: status 0, the exact ending clock and the captured data, not an abort. A retry vector and a target-abort vector next to them check that the ordering holds when TRDY# is absent.

// File: rtl/pci_mseq_pkg.sv
package pci_mseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        END_OK     = 2'd0,
        END_MABORT = 2'd1,
        END_TABORT = 2'd2,
        END_RETRY  = 2'd3
    } end_code_e;

    // strobes from the control FSM to the address/data path
    typedef struct packed {
        logic take_req;   // load host fields
        logic pick_data;  // mux: 0 address/command, 1 data/byte enables
        logic ad_en;      // AD output enable
        logic cbe_en;     // C/BE output enable
        logic grab_rd;    // load read data register
    } dp_ctl_t;

    function automatic logic even_par(input logic [31:0] ad, input logic [3:0] cbe);
        return ^{ad, cbe};
    endfunction

endpackage

// File: rtl/pci_mseq_ctl.sv
module pci_mseq_ctl
    import pci_mseq_pkg::*;
#(
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      req_wr,
    input  logic      devsel_n_i,
    input  logic      trdy_n_i,
    input  logic      stop_n_i,
    output logic      frame_n_o,
    output logic      frame_oe,
    output logic      irdy_n_o,
    output logic      irdy_oe,
    output dp_ctl_t   dp,
    output logic      done,
    output end_code_e status
);
    localparam int CW = $clog2(DEVSEL_LIMIT + 1);
    // last data clock (0-based) in which DEVSEL# may first appear
    localparam logic [CW-1:0] LAST = CW'(DEVSEL_LIMIT - 2);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    seq_state_e state_q, state_d;
    end_code_e  code_q, code_d;
    logic [CW-1:0] cnt_q;
    logic       seen_q, wr_q;
    logic       dev_now, seen_now, ready, trdy_now, stop_now;

    assign dev_now  = !devsel_n_i;
    assign trdy_now = !trdy_n_i;
    assign stop_now = !stop_n_i;
    assign seen_now = seen_q | dev_now;
    assign ready    = wr_q | (cnt_q != '0);

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (ready && trdy_now && dev_now) begin
                    state_d = ST_TURN; code_d = END_OK;
                end else if (ready && stop_now && !dev_now) begin
                    state_d = ST_TURN; code_d = END_TABORT;
                end else if (ready && stop_now && dev_now) begin
                    state_d = ST_TURN; code_d = END_RETRY;
                end else if (!seen_now && cnt_q == LAST) begin
                    state_d = ST_TURN; code_d = END_MABORT;
                end
            end
            ST_TURN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= END_OK;
            cnt_q   <= '0;
            seen_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (state_q == ST_IDLE && req) wr_q <= req_wr;
            if (state_q == ST_ADDR) begin
                cnt_q  <= '0;
                seen_q <= 1'b0;
            end else if (state_q == ST_DATA) begin
                if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
                seen_q <= seen_now;
            end
        end
    end

    always_comb begin
        frame_oe     = (state_q == ST_ADDR) || (state_q == ST_DATA);
        frame_n_o    = (state_q != ST_ADDR);
        irdy_oe      = (state_q != ST_IDLE);
        irdy_n_o     = (state_q != ST_DATA);
        dp.take_req  = (state_q == ST_IDLE) && req;
        dp.pick_data = (state_q == ST_DATA);
        dp.ad_en     = (state_q == ST_ADDR) || ((state_q == ST_DATA) && wr_q);
        dp.cbe_en    = frame_oe;
        dp.grab_rd   = (state_q == ST_DATA) && ready && trdy_now && dev_now && !wr_q;
        done         = (state_q == ST_TURN);
        status       = code_q;
    end

endmodule

// File: rtl/pci_mseq_dpath.sv
module pci_mseq_dpath
    import pci_mseq_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = AD_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  dp_ctl_t          dp,
    input  logic [CBE_W-1:0] req_cmd,
    input  logic [AD_W-1:0]  req_addr,
    input  logic [AD_W-1:0]  req_wdata,
    input  logic [CBE_W-1:0] req_be,
    input  logic [AD_W-1:0]  ad_i,
    output logic [AD_W-1:0]  ad_o,
    output logic             ad_oe,
    output logic [CBE_W-1:0] cbe_o,
    output logic             cbe_oe,
    output logic [AD_W-1:0]  rdata
);
    logic [AD_W-1:0]  addr_q, wdata_q, rd_q;
    logic [CBE_W-1:0] cmd_q, be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cmd_q   <= '0;
            be_q    <= '0;
            rd_q    <= '0;
        end else begin
            if (dp.take_req) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                cmd_q   <= req_cmd;
                be_q    <= req_be;
            end
            if (dp.grab_rd) rd_q <= ad_i;
        end
    end

    assign ad_o   = dp.pick_data ? wdata_q : addr_q;
    assign cbe_o  = dp.pick_data ? be_q : cmd_q;
    assign ad_oe  = dp.ad_en;
    assign cbe_oe = dp.cbe_en;
    assign rdata  = rd_q;

endmodule

// File: rtl/pci_mseq_par.sv
module pci_mseq_par
    import pci_mseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ad,
    input  logic [3:0]  cbe,
    input  logic        ad_en,
    output logic        par_o,
    output logic        par_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_o  <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par_o  <= even_par(ad, cbe);
            par_oe <= ad_en;
        end
    end
endmodule

// File: rtl/pci_mseq.sv
module pci_mseq
    import pci_mseq_pkg::*;
#(
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [3:0]  req_cmd,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    output logic        frame_n_o,
    output logic        frame_oe,
    output logic        irdy_n_o,
    output logic        irdy_oe,
    input  logic        devsel_n_i,
    input  logic        trdy_n_i,
    input  logic        stop_n_i,
    output logic [31:0] ad_o,
    output logic        ad_oe,
    input  logic [31:0] ad_i,
    output logic [3:0]  cbe_o,
    output logic        cbe_oe,
    output logic        par_o,
    output logic        par_oe,
    output logic        done,
    output logic [1:0]  status,
    output logic [31:0] rdata
);
    dp_ctl_t   dp;
    end_code_e code;

    pci_mseq_ctl #(.DEVSEL_LIMIT(DEVSEL_LIMIT)) u_ctl (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_cmd[0]),
        .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .frame_n_o(frame_n_o), .frame_oe(frame_oe),
        .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe),
        .dp(dp), .done(done), .status(code)
    );

    pci_mseq_dpath #(.AD_W(32), .CBE_W(4)) u_dp (
        .clk(clk), .rst(rst), .dp(dp),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
        .rdata(rdata)
    );

    pci_mseq_par u_par (
        .clk(clk), .rst(rst), .ad(ad_o), .cbe(cbe_o), .ad_en(ad_oe),
        .par_o(par_o), .par_oe(par_oe)
    );

    assign status = code;

endmodule

// File: rtl/pci_mseq_chk.sv
module pci_mseq_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_n_o,
    input logic        frame_oe,
    input logic        irdy_n_o,
    input logic        irdy_oe,
    input logic [31:0] ad_o,
    input logic        ad_oe,
    input logic [3:0]  cbe_o,
    input logic        cbe_oe,
    input logic        par_o,
    input logic        par_oe,
    input logic        done
);
    // R3
    single_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_oe && !frame_n_o) |=> (frame_oe && frame_n_o && irdy_oe && !irdy_n_o));

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_oe && !frame_n_o && !cbe_o[0]) |=> !ad_oe);

    // R9
    turn_lines_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (irdy_oe && irdy_n_o && !frame_oe && !ad_oe && !cbe_oe));

    // R9
    turn_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !irdy_oe));

    // R10
    parity_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |=> (par_oe && par_o == $past(^{ad_o, cbe_o})));

    // R10
    parity_release_chk: assert property (@(posedge clk) disable iff (rst)
        !ad_oe |=> !par_oe);
endmodule

bind pci_mseq pci_mseq_chk u_chk (
    .clk(clk), .rst(rst),
    .frame_n_o(frame_n_o), .frame_oe(frame_oe),
    .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe),
    .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
    .par_o(par_o), .par_oe(par_oe), .done(done)
);

// File: tb/pci_mseq_test.sv
module pci_mseq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [3:0]  req_cmd = 4'h0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = 4'h0;
    logic devsel_n_i = 1'b1, trdy_n_i = 1'b1, stop_n_i = 1'b1;
    logic [31:0] ad_i = '0;
    logic frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe, cbe_oe, par_o, par_oe, done;
    logic [31:0] ad_o, rdata;
    logic [3:0]  cbe_o;
    logic [1:0]  status;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pci_mseq uut (
        .clk(clk), .rst(rst), .req(req), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .frame_n_o(frame_n_o), .frame_oe(frame_oe), .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe),
        .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
        .par_o(par_o), .par_oe(par_oe), .done(done), .status(status), .rdata(rdata)
    );

    // {write, devsel_from, trdy_from, stop_from}: data-clock index (1-based) at
    // which the line goes low and stays low; 15 means never
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd1,  4'd1,  4'd15},  // write, zero wait
        {1'b1, 4'd2,  4'd3,  4'd15},  // write, wait states
        {1'b0, 4'd1,  4'd1,  4'd15},  // read, TRDY# during turnaround ignored
        {1'b0, 4'd3,  4'd5,  4'd15},  // read, slow target
        {1'b1, 4'd15, 4'd15, 4'd15},  // write, master abort
        {1'b0, 4'd15, 4'd15, 4'd15},  // read, master abort
        {1'b1, 4'd15, 4'd15, 4'd2},   // target abort
        {1'b1, 4'd1,  4'd15, 4'd2},   // retry
        {1'b0, 4'd1,  4'd2,  4'd2},   // TRDY# and STOP# together
        {1'b1, 4'd4,  4'd4,  4'd15},  // DEVSEL# at the limit clock
        {1'b0, 4'd2,  4'd15, 4'd3}    // read retry
    };

    task automatic check(input bit ok, input string req_tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // outcome from the requirements: ending data clock and status code
    function automatic void model(input logic [12:0] v, output int ec, output logic [1:0] es);
        bit wr = v[12];
        int dd = int'(v[11:8]);
        int td = int'(v[7:4]);
        int sd = int'(v[3:0]);
        bit seen = 0;
        ec = 99; es = 2'd0;
        for (int c = 1; c <= 20; c++) begin
            bit dv = (c >= dd);
            bit tr = (c >= td);
            bit st = (c >= sd);
            bit rdy = wr || (c >= 2);
            seen = seen | dv;
            if (rdy && tr && dv)       begin ec = c; es = 2'd0; return; end
            else if (rdy && st && !dv) begin ec = c; es = 2'd2; return; end
            else if (rdy && st && dv)  begin ec = c; es = 2'd3; return; end
            else if (!seen && c == 4)  begin ec = c; es = 2'd1; return; end
        end
    endfunction

    task automatic drive_target(input logic [12:0] v, input int c);
        devsel_n_i = !(c >= int'(v[11:8]));
        trdy_n_i   = !(c >= int'(v[7:4]));
        stop_n_i   = !(c >= int'(v[3:0]));
    endtask

    task automatic run(input int idx, input logic [12:0] v);
        bit wr = v[12];
        int ec;
        logic [1:0] es;
        int c;
        logic ep;
        logic [31:0] a  = 32'h4000_0000 + 32'(idx) * 32'h10;
        logic [31:0] wd = 32'hA5A5_0000 ^ 32'(idx * 7919);
        logic [3:0]  cmd = wr ? 4'h7 : 4'h6;
        logic [3:0]  be  = 4'(idx);
        model(v, ec, es);
        @(negedge clk);
        req = 1'b1; req_cmd = cmd; req_addr = a; req_wdata = wd; req_be = be;
        ad_i = 32'hC0DE_0000 | 32'(idx);
        @(negedge clk);
        req = 1'b0;
        // R2 address phase
        check(frame_oe && !frame_n_o && irdy_oe && irdy_n_o && ad_oe && cbe_oe,
              "R2", "addr controls", {frame_oe, frame_n_o, irdy_oe, irdy_n_o, ad_oe, cbe_oe}, 6'b101111);
        check(ad_o == a && cbe_o == cmd, "R2", "addr/cmd", ad_o, a);
        ep = ^{ad_o, cbe_o};
        @(negedge clk);
        c = 1;
        drive_target(v, c);
        // R3 single data phase
        check(frame_oe && frame_n_o && irdy_oe && !irdy_n_o, "R3", "frame/irdy",
              {frame_n_o, irdy_n_o}, 2'b10);
        check(par_oe && par_o == ep, "R10", "addr parity", {par_oe, par_o}, {1'b1, ep});
        if (wr) begin
            check(ad_oe && ad_o == wd && cbe_o == be, "R3", "write data", ad_o, wd);
        end else begin
            check(!ad_oe && cbe_oe && cbe_o == be, "R4", "read release", ad_oe, 0);
        end
        forever begin
            @(negedge clk);
            if (done || c >= 20) break;
            c++;
            drive_target(v, c);
        end
        check(done, "R9", "done seen", done, 1);
        check(c == ec, "R5", $sformatf("end clock vec %0d", idx), c, ec);
        case (es)
            2'd0: check(status == es, "R5", "status ok", status, es);
            2'd1: check(status == es, "R6", "status master abort", status, es);
            2'd2: check(status == es, "R7", "status target abort", status, es);
            default: check(status == es, "R8", "status retry", status, es);
        endcase
        if (!wr && es == 2'd0)
            check(rdata == ad_i, "R5", "read data", rdata, ad_i);
        check(irdy_oe && irdy_n_o && !frame_oe && !ad_oe && !cbe_oe, "R9", "turnaround lines",
              {irdy_oe, irdy_n_o, frame_oe, ad_oe, cbe_oe}, 5'b11000);
        if (wr)
            check(par_oe && par_o == ^{wd, be}, "R10", "data parity", {par_oe, par_o}, {1'b1, ^{wd, be}});
        else
            check(!par_oe, "R10", "par released on read", par_oe, 0);
        devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1;
        @(negedge clk);
        check(!done && !irdy_oe && !frame_oe && !ad_oe, "R9", "idle after turn",
              {done, irdy_oe, frame_oe, ad_oe}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe && !par_oe && !done, "R1", "in reset",
              {frame_oe, irdy_oe, ad_oe, cbe_oe, par_oe, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!frame_oe && !irdy_oe && !ad_oe && !done, "R1", "after reset",
              {frame_oe, irdy_oe, ad_oe, done}, 0);

        for (int i = 0; i < NV; i++) run(i, VEC[i]);

        // R1 reset in the middle of a data phase
        @(negedge clk);
        req = 1'b1; req_cmd = 4'h7; req_addr = 32'h1234_5678;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe && !par_oe && !done, "R1", "mid reset",
              {frame_oe, irdy_oe, ad_oe, cbe_oe, par_oe, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!frame_oe && !irdy_oe, "R1", "stays idle", {frame_oe, irdy_oe}, 0);
        run(20, {1'b1, 4'd1, 4'd2, 4'd15});

        finish_run();
    end
endmodule